// File: doc/BRIEF.md
# Pin-Multiplexed General-Purpose I/O Port

This block controls a 16-lane I/O port in which each usable pin either behaves as a plain software-controlled general-purpose pin or is handed to one of two on-chip peripheral functions. Three 16-bit registers steer it: an output/data latch, a direction register, and an assignment register. A one-bit assignment value of 0 keeps a pin under software control, and 1 gives the pin to a peripheral. The direction register has two roles. For a software-controlled pin it selects input or output. For a peripheral pin it selects which of the two functions owns the pad.

Registers are reached through a simple synchronous port with address, write enable, write data and combinational read data. Pad inputs are resynchronised through two flops before software reads them or a peripheral receives them. Ten of the sixteen lanes exist. The other six are tied off.

Each pin's role is one of four named states, decoded from its assignment and direction bits: GPIO_IN (assign 0, dir 0), GPIO_OUT (assign 0, dir 1), PERIPH0 (assign 1, dir 0) and PERIPH1 (assign 1, dir 1). Every transition between them is a register write that changes one of the two bits. The change takes effect on the clock edge that performs the write.

Top module: `pinmux_port`

## Requirements
- R1: Pin numbering is big-endian, so pin n maps to bus bit 15-n. Only pins 4–9 and 12–15 exist, which is mask 16'h0FCF on the bus. On the other bus bits, register reads return 0, writes are dropped, pad_oe and pad_out stay 0, and both peripheral inputs stay 0.
- R2: After reset the data, direction and assignment registers read 0, pad_oe is 0, and every pin is in GPIO_IN.
- R3: The data register is at byte address 0x950, direction at 0x952 and assignment at 0x954. A write to any other address changes nothing, and a read of any other address returns 0.
- R4: In GPIO_IN the pad output enable is 0. A read of the data register returns the pad input for that bit two clock edges after the pad changes, and not after only one edge.
- R5: In GPIO_OUT the pad output enable is 1, the pad is driven with the latched data bit, and a data register read returns that latched bit.
- R6: A write to the data register always updates the latch, whatever the pin's mode. A pin that later becomes GPIO_OUT drives the previously written value. In any GPIO mode pad_out carries the latched bit.
- R7: In PERIPH0, pad_out and pad_oe follow function 0's output and enable. Function 0's input receives the synchronised pad value, and function 1's input for that pin is 0.
- R8: In PERIPH1, pad_out and pad_oe follow function 1's output and enable. Function 1's input receives the synchronised pad value, and function 0's input for that pin is 0.
- R9: A data register read of a pin in PERIPH0 or PERIPH1 returns the synchronised pad value.
- R10: The direction and assignment registers read back the last value written to them, masked by 16'h0FCF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| pad_in | input | 16 | Raw pad input levels |
| pad_out | output | 16 | Pad drive values |
| pad_oe | output | 16 | Pad output enables |
| fn0_out | input | 16 | Peripheral function 0 drive values |
| fn0_oe | input | 16 | Peripheral function 0 output enables |
| fn0_in | output | 16 | Synchronised pad values to function 0 |
| fn1_out | input | 16 | Peripheral function 1 drive values |
| fn1_oe | input | 16 | Peripheral function 1 output enables |
| fn1_in | output | 16 | Synchronised pad values to function 1 |

## Verification
The bench targets the dual meaning of the direction bit. A design that ignored the assignment bit would drive peripheral pins from the latch, and a design that swapped the function select would route pads to the wrong peripheral and leave the other input nonzero. It checks the reserved lanes and unmapped addresses, where a missing mask would read back stray bits or a loose decoder would corrupt a register. It checks the two-edge input latency, which a design with one synchroniser stage or none would show one cycle early. It also writes the data latch while pins are inputs, which exposes a design that reads back the latch instead of the pad or gates latch writes on direction.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    typedef enum logic [1:0] {
        GPIO_IN  = 2'b00,
        GPIO_OUT = 2'b01,
        PERIPH0  = 2'b10,
        PERIPH1  = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        SEL_DATA,
        SEL_DIR,
        SEL_ASG,
        SEL_NONE
    } reg_sel_e;

    function automatic pin_mode_e decode_mode(input logic asg, input logic dir);
        return pin_mode_e'({asg, dir});
    endfunction

endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int              WIDTH     = 16,
    parameter int              AW        = 12,
    parameter logic [WIDTH-1:0] IMPL_MASK = 16'h0FCF,
    parameter logic [AW-1:0]   ADDR_DATA = 12'h950,
    parameter logic [AW-1:0]   ADDR_DIR  = 12'h952,
    parameter logic [AW-1:0]   ADDR_ASG  = 12'h954
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pad_sync,
    output logic [WIDTH-1:0] rdata,
    output logic [WIDTH-1:0] dat_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] asg_q
);
    reg_sel_e         sel;
    logic [WIDTH-1:0] wmasked;
    logic [WIDTH-1:0] data_view;

    always_comb begin
        if (addr == ADDR_DATA)      sel = SEL_DATA;
        else if (addr == ADDR_DIR)  sel = SEL_DIR;
        else if (addr == ADDR_ASG)  sel = SEL_ASG;
        else                        sel = SEL_NONE;
    end

    assign wmasked = wdata & IMPL_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q <= '0;
            dir_q <= '0;
            asg_q <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_DATA: dat_q <= wmasked;
                SEL_DIR:  dir_q <= wmasked;
                SEL_ASG:  asg_q <= wmasked;
                SEL_NONE: ;
            endcase
        end
    end

    // Only a GPIO output pin reads its latch; every other mode reads the pad.
    for (genvar i = 0; i < WIDTH; i++) begin : g_view
        assign data_view[i] = (decode_mode(asg_q[i], dir_q[i]) == GPIO_OUT) ? dat_q[i] : pad_sync[i];
    end

    always_comb begin
        unique case (sel)
            SEL_DATA: rdata = data_view & IMPL_MASK;
            SEL_DIR:  rdata = dir_q;
            SEL_ASG:  rdata = asg_q;
            SEL_NONE: rdata = '0;
        endcase
    end

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_DIR) |=> (dir_q == ($past(wdata) & IMPL_MASK))); // R10
    AST_ASG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_ASG) |=> (asg_q == ($past(wdata) & IMPL_MASK))); // R10
    AST_RSVD_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdata & ~IMPL_MASK) == '0)); // R1
    AST_STRAY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr != ADDR_DATA && addr != ADDR_DIR && addr != ADDR_ASG)
        |=> ($stable(dat_q) && $stable(dir_q) && $stable(asg_q))); // R3
endmodule

// File: rtl/pinmux_pin.sv
module pinmux_pin
    import pinmux_pkg::*;
(
    input  logic asg,
    input  logic dir,
    input  logic dat,
    input  logic pad_sync,
    input  logic f0_out,
    input  logic f0_oe,
    input  logic f1_out,
    input  logic f1_oe,
    output logic pad_out,
    output logic pad_oe,
    output logic f0_in,
    output logic f1_in
);
    pin_mode_e mode;

    assign mode = decode_mode(asg, dir);

    always_comb begin
        pad_out = 1'b0;
        pad_oe  = 1'b0;
        f0_in   = 1'b0;
        f1_in   = 1'b0;
        unique case (mode)
            GPIO_IN: begin
                pad_out = dat;
            end
            GPIO_OUT: begin
                pad_out = dat;
                pad_oe  = 1'b1;
            end
            PERIPH0: begin
                pad_out = f0_out;
                pad_oe  = f0_oe;
                f0_in   = pad_sync;
            end
            PERIPH1: begin
                pad_out = f1_out;
                pad_oe  = f1_oe;
                f1_in   = pad_sync;
            end
        endcase
    end
endmodule

// File: rtl/pinmux_port.sv
module pinmux_port #(
    parameter int               WIDTH     = 16,
    parameter int               AW        = 12,
    parameter logic [WIDTH-1:0] IMPL_MASK = 16'h0FCF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    input  logic [WIDTH-1:0] fn0_out,
    input  logic [WIDTH-1:0] fn0_oe,
    output logic [WIDTH-1:0] fn0_in,
    input  logic [WIDTH-1:0] fn1_out,
    input  logic [WIDTH-1:0] fn1_oe,
    output logic [WIDTH-1:0] fn1_in
);
    logic [WIDTH-1:0] pad_sync;
    logic [WIDTH-1:0] dat_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] asg_q;

    pinmux_sync #(.WIDTH(WIDTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pad_sync)
    );

    pinmux_regs #(.WIDTH(WIDTH), .AW(AW), .IMPL_MASK(IMPL_MASK)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .pad_sync (pad_sync),
        .rdata    (bus_rdata),
        .dat_q    (dat_q),
        .dir_q    (dir_q),
        .asg_q    (asg_q)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (IMPL_MASK[i]) begin : g_live
            pinmux_pin u_pin (
                .asg      (asg_q[i]),
                .dir      (dir_q[i]),
                .dat      (dat_q[i]),
                .pad_sync (pad_sync[i]),
                .f0_out   (fn0_out[i]),
                .f0_oe    (fn0_oe[i]),
                .f1_out   (fn1_out[i]),
                .f1_oe    (fn1_oe[i]),
                .pad_out  (pad_out[i]),
                .pad_oe   (pad_oe[i]),
                .f0_in    (fn0_in[i]),
                .f1_in    (fn1_in[i])
            );
        end else begin : g_tied
            assign pad_out[i] = 1'b0;
            assign pad_oe[i]  = 1'b0;
            assign fn0_in[i]  = 1'b0;
            assign fn1_in[i]  = 1'b0;
        end
    end

    AST_PAD_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_oe | pad_out | fn0_in | fn1_in) & ~IMPL_MASK) == '0)); // R1
    AST_IN_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~asg_q & ~dir_q) == '0)); // R4
    AST_OUT_FROM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out ^ dat_q) & ~asg_q & IMPL_MASK) == '0)); // R6
    AST_FN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((fn0_in & fn1_in) == '0)); // R7
    AST_FN1_ONLY_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
        ((fn1_in & ~(asg_q & dir_q)) == '0)); // R8
endmodule

// File: tb/pinmux_port_bench.sv
module pinmux_port_bench;
    localparam logic [15:0] MASK = 16'h0FCF;
    localparam logic [11:0] A_DAT = 12'h950;
    localparam logic [11:0] A_DIR = 12'h952;
    localparam logic [11:0] A_ASG = 12'h954;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe;
    logic [15:0] fn0_out = '0, fn0_oe = '0, fn1_out = '0, fn1_oe = '0;
    logic [15:0] fn0_in, fn1_in;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [15:0] m_dat = '0, m_dir = '0, m_asg = '0;

    always #2.5 clk = ~clk;

    pinmux_port u_pinmux_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .fn0_out(fn0_out), .fn0_oe(fn0_oe),
        .fn0_in(fn0_in), .fn1_out(fn1_out), .fn1_oe(fn1_oe), .fn1_in(fn1_in)
    );

    function automatic logic [15:0] exp_oe();
        return MASK & ((~m_asg & m_dir) | (m_asg & ~m_dir & fn0_oe) | (m_asg & m_dir & fn1_oe));
    endfunction
    function automatic logic [15:0] exp_out();
        return MASK & ((~m_asg & m_dat) | (m_asg & ~m_dir & fn0_out) | (m_asg & m_dir & fn1_out));
    endfunction
    function automatic logic [15:0] exp_rd_dat(input logic [15:0] sync);
        return MASK & (((~m_asg & m_dir) & m_dat) | (~(~m_asg & m_dir) & sync));
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives a write at a negedge; the register takes it at the next posedge.
    task automatic bus_write(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        if (a == A_DAT) m_dat = d & MASK;
        else if (a == A_DIR) m_dir = d & MASK;
        else if (a == A_ASG) m_asg = d & MASK;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [15:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic check_all(input logic [15:0] sync, input string tag);
        logic [15:0] rd;
        check({tag, " R5/R7/R8 pad_oe"}, pad_oe, exp_oe());
        check({tag, " R6/R7/R8 pad_out"}, pad_out, exp_out());
        check({tag, " R7 fn0_in"}, fn0_in, MASK & m_asg & ~m_dir & sync);
        check({tag, " R8 fn1_in"}, fn1_in, MASK & m_asg & m_dir & sync);
        bus_read(A_DAT, rd); check({tag, " R4/R5/R9 data read"}, rd, exp_rd_dat(sync));
        bus_read(A_DIR, rd); check({tag, " R10 dir read"}, rd, m_dir);
        bus_read(A_ASG, rd); check({tag, " R10 asg read"}, rd, m_asg);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        check("R2 pad_oe after reset", pad_oe, 16'h0000);
        bus_read(A_DAT, rd); check("R2 data after reset", rd, 16'h0000);
        bus_read(A_DIR, rd); check("R2 dir after reset", rd, 16'h0000);
        bus_read(A_ASG, rd); check("R2 asg after reset", rd, 16'h0000);

        // R1 reserved lanes
        bus_write(A_DIR, 16'hFFFF);
        bus_write(A_DAT, 16'hFFFF);
        bus_read(A_DIR, rd); check("R1 dir reserved bits", rd, 16'h0FCF);
        check("R1 pad_oe reserved lanes", pad_oe, 16'h0FCF);
        check("R1 pad_out reserved lanes", pad_out, 16'h0FCF);

        // R3 unmapped addresses
        bus_write(12'h956, 16'h0000);
        bus_write(12'h951, 16'h0000);
        bus_read(A_DIR, rd); check("R3 stray write kept dir", rd, 16'h0FCF);
        bus_read(A_DAT, rd); check("R3 stray write kept data", rd, 16'h0FCF);
        bus_read(12'h956, rd); check("R3 unmapped read", rd, 16'h0000);

        // R6 latch written while inputs, then outputs reveal it
        bus_write(A_DIR, 16'h0000);
        pad_in = 16'h0000;
        bus_write(A_DAT, 16'h0A45);
        @(negedge clk);
        bus_read(A_DAT, rd); check("R6 input reads pad not latch", rd, 16'h0000);
        check("R6 pad_out latched in input mode", pad_out, 16'h0A45 & MASK);
        bus_write(A_DIR, 16'hFFFF);
        check("R6 latched value driven", pad_out, 16'h0A45 & MASK);
        bus_read(A_DAT, rd); check("R5 output reads latch", rd, 16'h0A45 & MASK);

        // R4 two-edge input latency
        bus_write(A_DIR, 16'h0000);
        @(negedge clk); @(negedge clk);
        pad_in = 16'hFFFF;
        @(negedge clk);
        bus_read(A_DAT, rd); check("R4 not visible after one edge", rd, 16'h0000);
        @(negedge clk);
        bus_read(A_DAT, rd); check("R4 visible after two edges", rd, MASK);

        // R7/R8/R9 directed peripheral split
        fn0_out = 16'h00C3; fn0_oe = 16'h0F0F; fn1_out = 16'h0F00; fn1_oe = 16'h00F0;
        bus_write(A_ASG, 16'hFFFF);
        bus_write(A_DIR, 16'h0F00);
        @(negedge clk);
        check_all(pad_in, "directed");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            logic [11:0] a;
            logic [15:0] w;
            int pick;
            pick = $urandom_range(0, 9);
            a = (pick < 3) ? A_DAT : (pick < 6) ? A_DIR : (pick < 9) ? A_ASG : 12'h958;
            w = 16'($urandom);
            @(negedge clk);
            pad_in = 16'($urandom);
            fn0_out = 16'($urandom); fn0_oe = 16'($urandom);
            fn1_out = 16'($urandom); fn1_oe = 16'($urandom);
            bus_write(a, w);
            @(negedge clk);
            check_all(pad_in, "random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule